// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The local component keeps a per-branch outcome history, selected by low PC bits, and that history picks a 3-bit saturating counter. The global component uses a shift register holding the last outcomes of all branches to pick a 2-bit counter. A third table of 2-bit counters, also indexed by the global history, decides which component supplies the answer. It learns which component has been right more often for each history pattern.

The fetch side presents a PC on the lookup port and gets a direction back in the same cycle, together with the global history seen by that lookup. The caller keeps that history as a checkpoint and returns it with the branch when the branch resolves. Each lookup shifts the predicted direction into the global history straight away. When the execute side reports a resolved branch on the update port, the block trains all three tables. If that branch was mispredicted, the block rebuilds the global history from the checkpoint plus the real outcome. Table sizes are parameters; the defaults give 1024 local histories of 10 bits, 1024 local counters, and 4096 global and 4096 choice counters.

Top module: `tourney_bp`

## Requirements
- R1: After reset the global history reads zero and every lookup predicts not-taken: all direction counters start weakly not-taken, and every choice counter starts weakly favouring global.
- R2: A lookup with `pred_valid_i` high reports, on `pred_ghist_o`, the history it used. At the next edge the history becomes `{old[GHIST_W-2:0], predicted}`, so the newest outcome is in bit 0.
- R3: An update with `upd_valid_i` and `upd_mispred_i` both high sets the history at the next edge to `{upd_ghist_i[GHIST_W-2:0], upd_taken_i}`. This repair wins over a lookup in the same cycle.
- R4: The global 2-bit counter is selected by the full global history: the live history on lookup, `upd_ghist_i` on update. It predicts taken when its value is 2 or 3, moves one step toward the outcome and saturates. From the strongly-taken state, two not-taken outcomes are needed to flip the prediction.
- R5: The local history entry is selected by `pc[PC_LSB +: 10]` (bits 11:2 by default). Every update shifts the outcome into bit 0 of the entry for `upd_pc_i`. Branches with different index bits keep separate histories.
- R6: The local 3-bit counter is selected by the 10-bit local history. An update uses the history from before its own shift. The counter predicts taken at values 4 to 7, resets to 3, and saturates at 0 and 7.
- R7: The choice counter is selected by the global history. A value of 2 or 3 selects the global prediction, and 0 or 1 selects the local one. On an update it is trained only when the local and global predictions (read at the update indices) disagree: up when global was right, down when local was right.
- R8: An update with `upd_mispred_i` low leaves the global history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid_i | input | 1 | Lookup is real; shift the prediction into the history |
| pred_pc_i | input | PC_W | Fetch PC of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_ghist_o | output | GHIST_W | Global history used by this lookup (checkpoint) |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_mispred_i | input | 1 | The branch was mispredicted; repair the history |
| upd_ghist_i | input | GHIST_W | Checkpointed history returned with the branch |

## Verification
The history assertions assume that reset is held low for at least one clock edge before checking starts, and that the control inputs carry no unknown values once reset is released. They also treat `upd_ghist_i` as any value at all; they do not check that it matches an earlier checkpoint. The bench holds reset for several edges and changes every input only on the falling edge. It drives all ports to defined values from time zero. Because training runs at the update indices, the bench can build any global-history state it needs through mispredict updates with chosen checkpoints.

// File: rtl/tourney_bp_pkg.sv
// Package: shared types and default sizes for the tournament direction predictor.
// Assumes: nothing; holds only constants and types.
package tourney_bp_pkg;

    // Default sizes of the component tables.
    localparam int unsigned DEF_LHT_ENTRIES = 1024;
    localparam int unsigned DEF_LHIST_W     = 10;
    localparam int unsigned DEF_LCTR_W      = 3;
    localparam int unsigned DEF_GHIST_W     = 12;
    localparam int unsigned DEF_GCTR_W      = 2;
    localparam int unsigned DEF_CCTR_W      = 2;

    // Which component the choice counter selects.
    typedef enum logic {
        PICK_LOCAL  = 1'b0,
        PICK_GLOBAL = 1'b1
    } pick_e;

endpackage

// File: rtl/tourney_bp_ctr_table.sv
// Module: table of saturating counters with one lookup read, one update
// read and one update write. The prediction is the counter's top bit.
// Assumes: ENTRIES == 2**IDX_W; the update reads the pre-write value, and
// a lookup to the entry being written in the same cycle sees the old value.
module tourney_bp_ctr_table #(
    parameter int unsigned ENTRIES = 4096,
    parameter int unsigned IDX_W   = 12,
    parameter int unsigned CTR_W   = 2,
    parameter int unsigned RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up,
    output logic             upd_msb
);

    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(RST_VAL);

    logic [CTR_W-1:0] mem [ENTRIES];
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] nxt;

    // Read the lookup and update entries.
    always_comb begin
        rd_msb  = mem[rd_idx][CTR_W-1];
        cur     = mem[upd_idx];
        upd_msb = cur[CTR_W-1];
    end

    // Step the updated counter one way and hold it at its limits.
    always_comb begin
        if (upd_up) begin
            nxt = (cur == CTR_MAX) ? cur : cur + 1'b1;
        end else begin
            nxt = (cur == '0) ? cur : cur - 1'b1;
        end
    end

    // Reset every counter to its initial value; otherwise write the update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                mem[i] <= CTR_INIT;
            end
        end else if (upd_en) begin
            mem[upd_idx] <= nxt;
        end
    end

endmodule

// File: rtl/tourney_bp_hist_table.sv
// Module: per-branch outcome histories. Each update shifts the outcome into
// bit 0 of the selected entry.
// Assumes: ENTRIES == 2**IDX_W and HIST_W >= 2; the update port returns the
// history from before its own shift.
module tourney_bp_hist_table #(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned HIST_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_bit,
    output logic [HIST_W-1:0] upd_hist
);

    logic [HIST_W-1:0] mem [ENTRIES];

    // Read the lookup history and the history to be trained.
    always_comb begin
        rd_hist  = mem[rd_idx];
        upd_hist = mem[upd_idx];
    end

    // Clear all histories on reset; otherwise shift the outcome in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                mem[i] <= '0;
            end
        end else if (upd_en) begin
            mem[upd_idx] <= {upd_hist[HIST_W-2:0], upd_bit};
        end
    end

endmodule

// File: rtl/tourney_bp_ghist.sv
// Module: global history shift register. A lookup shifts in the prediction,
// and a repair replaces the register with checkpoint plus actual outcome.
// Assumes: W >= 2; a repair and a lookup in the same cycle keep the repair.
module tourney_bp_ghist #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spec_en,
    input  logic         spec_bit,
    input  logic         fix_en,
    input  logic [W-1:0] fix_ckpt,
    input  logic         fix_bit,
    output logic [W-1:0] hist_o
);

    logic [W-1:0] hist_q;

    // Repair first, then the speculative shift, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (fix_en) begin
            hist_q <= {fix_ckpt[W-2:0], fix_bit};
        end else if (spec_en) begin
            hist_q <= {hist_q[W-2:0], spec_bit};
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/tourney_bp.sv
// Module: tournament branch direction predictor (top). A local predictor
// (per-branch history -> 3-bit counters) and a global predictor
// (global history -> 2-bit counters) are arbitrated by choice counters
// indexed by the global history.
// Assumes: the caller returns pred_ghist_o of each lookup on upd_ghist_i
// when that branch resolves; lookup output is combinational from state.
module tourney_bp
    import tourney_bp_pkg::*;
#(
    parameter int unsigned PC_W        = 32,
    parameter int unsigned PC_LSB      = 2,
    parameter int unsigned LHT_ENTRIES = DEF_LHT_ENTRIES,
    parameter int unsigned LHIST_W     = DEF_LHIST_W,
    parameter int unsigned LCTR_W      = DEF_LCTR_W,
    parameter int unsigned GHIST_W     = DEF_GHIST_W,
    parameter int unsigned GCTR_W      = DEF_GCTR_W,
    parameter int unsigned CCTR_W      = DEF_CCTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pred_valid_i,
    input  logic [PC_W-1:0]    pred_pc_i,
    output logic               pred_taken_o,
    output logic [GHIST_W-1:0] pred_ghist_o,
    input  logic               upd_valid_i,
    input  logic [PC_W-1:0]    upd_pc_i,
    input  logic               upd_taken_i,
    input  logic               upd_mispred_i,
    input  logic [GHIST_W-1:0] upd_ghist_i
);

    localparam int unsigned LHT_IDX_W   = $clog2(LHT_ENTRIES);
    localparam int unsigned LPT_ENTRIES = 1 << LHIST_W;
    localparam int unsigned GPT_ENTRIES = 1 << GHIST_W;
    localparam int unsigned PC_TOP      = PC_LSB + LHT_IDX_W;
    localparam int unsigned LCTR_RST    = (1 << (LCTR_W - 1)) - 1;
    localparam int unsigned GCTR_RST    = (1 << (GCTR_W - 1)) - 1;
    localparam int unsigned CCTR_RST    = 1 << (CCTR_W - 1);

    logic [LHT_IDX_W-1:0] lht_rd_idx;
    logic [LHT_IDX_W-1:0] lht_upd_idx;
    logic [LHIST_W-1:0]   lhist_rd;
    logic [LHIST_W-1:0]   lhist_upd;
    logic [GHIST_W-1:0]   ghist;
    logic                 loc_rd_msb;
    logic                 loc_upd_msb;
    logic                 glb_rd_msb;
    logic                 glb_upd_msb;
    logic                 cho_rd_msb;
    logic                 unused_cho_upd_msb;
    logic                 cho_train;
    logic                 cho_toward_glb;
    logic                 repair;
    pick_e                pick;
    logic                 unused_pc_bits;

    // Select the local history entries from the PC index bits.
    assign lht_rd_idx  = pred_pc_i[PC_LSB +: LHT_IDX_W];
    assign lht_upd_idx = upd_pc_i[PC_LSB +: LHT_IDX_W];
    assign unused_pc_bits = ^{pred_pc_i[PC_W-1:PC_TOP], pred_pc_i[PC_LSB-1:0],
                              upd_pc_i[PC_W-1:PC_TOP], upd_pc_i[PC_LSB-1:0]};

    tourney_bp_hist_table #(
        .ENTRIES (LHT_ENTRIES),
        .IDX_W   (LHT_IDX_W),
        .HIST_W  (LHIST_W)
    ) u_lht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lht_rd_idx),
        .rd_hist  (lhist_rd),
        .upd_en   (upd_valid_i),
        .upd_idx  (lht_upd_idx),
        .upd_bit  (upd_taken_i),
        .upd_hist (lhist_upd)
    );

    tourney_bp_ctr_table #(
        .ENTRIES (LPT_ENTRIES),
        .IDX_W   (LHIST_W),
        .CTR_W   (LCTR_W),
        .RST_VAL (LCTR_RST)
    ) u_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lhist_rd),
        .rd_msb  (loc_rd_msb),
        .upd_en  (upd_valid_i),
        .upd_idx (lhist_upd),
        .upd_up  (upd_taken_i),
        .upd_msb (loc_upd_msb)
    );

    tourney_bp_ctr_table #(
        .ENTRIES (GPT_ENTRIES),
        .IDX_W   (GHIST_W),
        .CTR_W   (GCTR_W),
        .RST_VAL (GCTR_RST)
    ) u_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_msb  (glb_rd_msb),
        .upd_en  (upd_valid_i),
        .upd_idx (upd_ghist_i),
        .upd_up  (upd_taken_i),
        .upd_msb (glb_upd_msb)
    );

    // Train the choice only when the two components disagreed.
    assign cho_train      = upd_valid_i && (loc_upd_msb != glb_upd_msb);
    assign cho_toward_glb = (glb_upd_msb == upd_taken_i);

    tourney_bp_ctr_table #(
        .ENTRIES (GPT_ENTRIES),
        .IDX_W   (GHIST_W),
        .CTR_W   (CCTR_W),
        .RST_VAL (CCTR_RST)
    ) u_choice (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_msb  (cho_rd_msb),
        .upd_en  (cho_train),
        .upd_idx (upd_ghist_i),
        .upd_up  (cho_toward_glb),
        .upd_msb (unused_cho_upd_msb)
    );

    // Pick the component named by the choice counter.
    always_comb begin
        pick         = pick_e'(cho_rd_msb);
        pred_taken_o = (pick == PICK_GLOBAL) ? glb_rd_msb : loc_rd_msb;
    end

    assign repair = upd_valid_i && upd_mispred_i;

    tourney_bp_ghist #(
        .W (GHIST_W)
    ) u_ghist (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (pred_valid_i),
        .spec_bit (pred_taken_o),
        .fix_en   (repair),
        .fix_ckpt (upd_ghist_i),
        .fix_bit  (upd_taken_i),
        .hist_o   (ghist)
    );

    assign pred_ghist_o = ghist;

endmodule

// File: rtl/tourney_bp_chk.sv
// Module: assertion checker for the global history behaviour of tourney_bp,
// attached by bind below.
// Assumes: reset is held low for at least one edge at start-up.
module tourney_bp_chk #(
    parameter int unsigned GHIST_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pred_valid_i,
    input logic               pred_taken_o,
    input logic [GHIST_W-1:0] pred_ghist_o,
    input logic               upd_valid_i,
    input logic               upd_mispred_i,
    input logic               upd_taken_i,
    input logic [GHIST_W-1:0] upd_ghist_i
);

    // R1: reset clears the global history.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> pred_ghist_o == '0);

    // R1: the prediction is never unknown outside reset.
    assert_pred_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken_o));

    // R2: a lookup shifts its own prediction into bit 0.
    assert_spec_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && !(upd_valid_i && upd_mispred_i)) |=>
        pred_ghist_o == {$past(pred_ghist_o[GHIST_W-2:0]), $past(pred_taken_o)});

    // R3: a mispredict rebuilds the history from the checkpoint.
    assert_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_mispred_i) |=>
        pred_ghist_o == {$past(upd_ghist_i[GHIST_W-2:0]), $past(upd_taken_i)});

    // R8: without lookup or repair the history holds.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid_i && !(upd_valid_i && upd_mispred_i)) |=> $stable(pred_ghist_o));

endmodule

bind tourney_bp tourney_bp_chk #(.GHIST_W(GHIST_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_valid_i  (pred_valid_i),
    .pred_taken_o  (pred_taken_o),
    .pred_ghist_o  (pred_ghist_o),
    .upd_valid_i   (upd_valid_i),
    .upd_mispred_i (upd_mispred_i),
    .upd_taken_i   (upd_taken_i),
    .upd_ghist_i   (upd_ghist_i)
);

// File: tb/tourney_bp_tb.sv
// Bench: directed scenarios for tourney_bp, one task each, with own checks.
module tourney_bp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid_i = 1'b0;
    logic [31:0] pred_pc_i = '0;
    logic        pred_taken_o;
    logic [11:0] pred_ghist_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_taken_i = 1'b0;
    logic        upd_mispred_i = 1'b0;
    logic [11:0] upd_ghist_i = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] PC_SET = 32'h0000_0FFC;  // history index 1023
    localparam logic [31:0] PC_GLB = 32'h0000_0080;  // index 32
    localparam logic [31:0] PC_LOC = 32'h0000_0040;  // index 16
    localparam logic [31:0] PC_MIS = 32'h0000_0200;  // index 128
    localparam logic [31:0] PC_AUX = 32'h0000_0300;  // index 192

    tourney_bp u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pred_valid_i  (pred_valid_i),
        .pred_pc_i     (pred_pc_i),
        .pred_taken_o  (pred_taken_o),
        .pred_ghist_o  (pred_ghist_o),
        .upd_valid_i   (upd_valid_i),
        .upd_pc_i      (upd_pc_i),
        .upd_taken_i   (upd_taken_i),
        .upd_mispred_i (upd_mispred_i),
        .upd_ghist_i   (upd_ghist_i)
    );

    always #2 clk = ~clk;

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_gh(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, exp);
        end
    endtask

    // Look at the prediction without shifting the history.
    task automatic peek(input logic [31:0] pc, input logic exp, input string tag);
        @(negedge clk);
        pred_valid_i = 1'b0;
        pred_pc_i    = pc;
        #1;
        chk_bit(tag, pred_taken_o, exp);
    endtask

    task automatic peek_gh(input logic [11:0] exp, input string tag);
        @(negedge clk);
        #1;
        chk_gh(tag, pred_ghist_o, exp);
    endtask

    // Real lookup: check direction and history, then let one edge pass.
    task automatic lookup(input logic [31:0] pc, input logic exp_t,
                          input logic [11:0] exp_gh, input string tag);
        @(negedge clk);
        pred_valid_i = 1'b1;
        pred_pc_i    = pc;
        #1;
        chk_bit(tag, pred_taken_o, exp_t);
        chk_gh(tag, pred_ghist_o, exp_gh);
        @(posedge clk);
        #1;
        pred_valid_i = 1'b0;
    endtask

    task automatic update(input logic [31:0] pc, input logic taken,
                          input logic mis, input logic [11:0] gh);
        @(negedge clk);
        upd_valid_i   = 1'b1;
        upd_pc_i      = pc;
        upd_taken_i   = taken;
        upd_mispred_i = mis;
        upd_ghist_i   = gh;
        @(posedge clk);
        #1;
        upd_valid_i   = 1'b0;
        upd_mispred_i = 1'b0;
    endtask

    // Set the history to an even value by a not-taken repair from PC_SET.
    task automatic set_gh_even(input logic [11:0] v);
        update(PC_SET, 1'b0, 1'b1, v >> 1);
    endtask

    task automatic t_reset;
        peek(PC_GLB, 1'b0, "R1 reset predicts not-taken");
        peek_gh(12'h000, "R1 reset history zero");
    endtask

    task automatic t_global_hyst;
        set_gh_even(12'h0A4);
        peek_gh(12'h0A4, "R3 repair from checkpoint");
        peek(PC_GLB, 1'b0, "R4 weakly not-taken at start");
        update(PC_GLB, 1'b1, 1'b0, 12'h0A4);
        peek_gh(12'h0A4, "R8 plain update keeps history");
        peek(PC_GLB, 1'b1, "R4 one taken flips weak counter");
        update(PC_GLB, 1'b1, 1'b0, 12'h0A4);
        peek(PC_GLB, 1'b1, "R4 strongly taken");
        update(PC_GLB, 1'b0, 1'b0, 12'h0A4);
        peek(PC_GLB, 1'b1, "R4 one not-taken keeps taken");
        update(PC_GLB, 1'b0, 1'b0, 12'h0A4);
        peek(PC_GLB, 1'b0, "R4 second not-taken flips");
    endtask

    // Choice at 0x0A4 was moved to local by the last disagreement above.
    task automatic t_choice;
        update(PC_LOC, 1'b1, 1'b0, 12'h300);
        peek(PC_LOC, 1'b1, "R7 local chosen over not-taken global");
        peek(PC_GLB, 1'b0, "R5 separate history per index");
    endtask

    task automatic t_spec_shift;
        lookup(PC_LOC, 1'b1, 12'h0A4, "R2 lookup at 0x0A4");
        lookup(PC_LOC, 1'b0, 12'h149, "R2 taken shifted into bit 0");
        peek_gh(12'h292, "R2 not-taken shifted into bit 0");
    endtask

    task automatic t_priority;
        @(negedge clk);
        pred_valid_i  = 1'b1;
        pred_pc_i     = PC_LOC;
        upd_valid_i   = 1'b1;
        upd_pc_i      = PC_MIS;
        upd_taken_i   = 1'b1;
        upd_mispred_i = 1'b1;
        upd_ghist_i   = 12'h7FF;
        @(posedge clk);
        #1;
        pred_valid_i  = 1'b0;
        upd_valid_i   = 1'b0;
        upd_mispred_i = 1'b0;
        peek_gh(12'hFFF, "R3 repair wins over lookup");
    endtask

    // Local counter for history 0 driven down past zero, then one step up.
    task automatic t_local_low;
        for (int i = 0; i < 7; i++) begin
            set_gh_even(12'h0A4);
        end
        peek(PC_SET, 1'b0, "R6 counter at floor predicts not-taken");
        update(PC_AUX, 1'b1, 1'b0, 12'h600);
        peek(PC_SET, 1'b0, "R6 saturated at zero, one step stays not-taken");
    endtask

    // PC_LOC trained taken until its history is all ones, then saturate.
    task automatic t_local_high;
        for (int i = 0; i < 9; i++) begin
            update(PC_LOC, 1'b1, 1'b0, 12'h500);
        end
        peek(PC_LOC, 1'b0, "R5 all-ones history selects fresh counter");
        update(PC_LOC, 1'b1, 1'b0, 12'h500);
        peek(PC_LOC, 1'b1, "R6 one taken makes counter 4");
        for (int i = 0; i < 5; i++) begin
            update(PC_LOC, 1'b1, 1'b0, 12'h500);
        end
        peek(PC_LOC, 1'b1, "R6 saturated at seven stays taken");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_global_hyst();
        t_choice();
        t_spec_shift();
        t_priority();
        t_local_low();
        t_local_high();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule